// File: doc/BRIEF.md
# ALU with Condition-Code Register

This block is the arithmetic and logic unit of a small 32-bit teaching processor. A 4-bit function code picks one of four operations on two register operands: add, subtract, bitwise AND and bitwise XOR. The result is presented combinationally on the same cycle, so the surrounding pipeline can write it back to the destination register (the one that supplied operand B).

Alongside the result the block keeps three single-bit condition flags: zero, negative and signed overflow. The flags sit in a register that loads on the rising clock edge. It loads only when the set-flags enable is high and the function code is valid. Instruction decode raises the enable for arithmetic and logical instructions, and later conditional moves and branches read the flags. Function codes outside the four defined ones produce a zero result and raise an invalid-function output. They never disturb the flags.

Top module: `cc_alu`

## Requirements
- R1: With function code 0 the result is operand B plus operand A, modulo 2^32, on the same cycle.
- R2: With function code 1 the result is operand B minus operand A, modulo 2^32, on the same cycle.
- R3: Function code 2 yields A AND B and function code 3 yields A XOR B, on the same cycle.
- R4: After a clock edge where the enable is high and the code is valid (0 to 3), the zero flag is 1 exactly when that cycle's result was zero. The negative flag equals bit 31 of that result.
- R5: For function code 0 with the enable high, the overflow flag becomes 1 exactly when A and B have the same bit 31 and the result's bit 31 differs from it.
- R6: For function code 1 with the enable high, the overflow flag becomes 1 exactly when A and B differ in bit 31 and the result's bit 31 differs from B's bit 31.
- R7: Function codes 2 and 3 with the enable high clear the overflow flag.
- R8: While the enable is low, all three flags keep their values across clock edges, whatever the operands and function code.
- R9: Function codes 4 to 15 give a zero result and drive the invalid-function output to 1, which is 0 for codes 0 to 3. They leave all three flags unchanged even with the enable high.
- R10: A clock edge with synchronous reset high sets zero=1, negative=0 and overflow=0. Reset takes priority over the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_a | input | 32 | Operand A (source register value) |
| op_b | input | 32 | Operand B (destination register value) |
| func | input | 4 | Function code: 0 add, 1 subtract, 2 AND, 3 XOR |
| flag_en | input | 1 | Set-flags enable for this cycle's operation |
| result | output | 32 | Combinational operation result |
| zf | output | 1 | Registered zero flag |
| sf | output | 1 | Registered negative flag |
| of | output | 1 | Registered signed-overflow flag |
| bad_func | output | 1 | High when the function code is not 0 to 3 |

## Verification
The hardest case to observe is a flag update that should not happen. An invalid code with the enable high, or any code with the enable low, produces a result that would move the flags if it were wrongly latched. The stimulus first drives the flags into a state the blocked operation would change. It sets the negative flag with a negative difference, or the overflow flag with a wrapping add. It then applies the blocked operation and reads the flags on the following cycle. Overflow in both directions is reached with operands chosen at the signed limits.

// File: rtl/alu_cc_pkg.sv
`timescale 1ns/1ps
package alu_cc_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_AND = 2'd2,
        OP_XOR = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } cc_flags_t;

    localparam cc_flags_t CC_RESET = '{zero: 1'b1, neg: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/alu_func_decode.sv
`timescale 1ns/1ps
module alu_func_decode
    import alu_cc_pkg::*;
#(
    parameter int FUNC_W = 4
) (
    input  logic [FUNC_W-1:0] func,
    output alu_op_e           op,
    output logic              valid
);
    localparam int NUM_OPS = 4;

    always_comb begin
        if (func < FUNC_W'(NUM_OPS)) begin
            valid = 1'b1;
            op    = alu_op_e'(func[1:0]);
        end else begin
            valid = 1'b0;
            op    = OP_ADD;
        end
    end

endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
    import alu_cc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  alu_op_e          op,
    input  logic             valid,
    output logic [WIDTH-1:0] result,
    output cc_flags_t        next_flags
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum_v;
    logic [WIDTH-1:0] diff_v;
    logic             ovf_add;
    logic             ovf_sub;

    assign sum_v   = b + a;
    assign diff_v  = b - a;
    assign ovf_add = (a[MSB] == b[MSB]) && (sum_v[MSB] != a[MSB]);
    assign ovf_sub = (a[MSB] != b[MSB]) && (diff_v[MSB] != b[MSB]);

    always_comb begin
        result         = '0;
        next_flags.ovf = 1'b0;
        if (valid) begin
            unique case (op)
                OP_ADD: begin
                    result         = sum_v;
                    next_flags.ovf = ovf_add;
                end
                OP_SUB: begin
                    result         = diff_v;
                    next_flags.ovf = ovf_sub;
                end
                OP_AND: result = a & b;
                OP_XOR: result = a ^ b;
            endcase
        end
        next_flags.zero = (result == '0);
        next_flags.neg  = result[MSB];
    end

endmodule

// File: rtl/cc_flag_reg.sv
`timescale 1ns/1ps
module cc_flag_reg
    import alu_cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  cc_flags_t d,
    output cc_flags_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= CC_RESET;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/cc_alu.sv
`timescale 1ns/1ps
module cc_alu
    import alu_cc_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int FUNC_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    input  logic [FUNC_W-1:0] func,
    input  logic              flag_en,
    output logic [WIDTH-1:0]  result,
    output logic              zf,
    output logic              sf,
    output logic              of,
    output logic              bad_func
);
    alu_op_e   op_sel;
    logic      op_valid;
    cc_flags_t flags_d;
    cc_flags_t flags_q;

    alu_func_decode #(.FUNC_W(FUNC_W)) u_decode (
        .func  (func),
        .op    (op_sel),
        .valid (op_valid)
    );

    alu_datapath #(.WIDTH(WIDTH)) u_datapath (
        .a          (op_a),
        .b          (op_b),
        .op         (op_sel),
        .valid      (op_valid),
        .result     (result),
        .next_flags (flags_d)
    );

    cc_flag_reg u_flags (
        .clk  (clk),
        .rst  (rst),
        .load (flag_en && op_valid),
        .d    (flags_d),
        .q    (flags_q)
    );

    assign zf       = flags_q.zero;
    assign sf       = flags_q.neg;
    assign of       = flags_q.ovf;
    assign bad_func = !op_valid;

endmodule

// File: rtl/cc_alu_checker.sv
`timescale 1ns/1ps
module cc_alu_checker #(
    parameter int WIDTH  = 32,
    parameter int FUNC_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [WIDTH-1:0]  op_a,
    input logic [WIDTH-1:0]  op_b,
    input logic [FUNC_W-1:0] func,
    input logic              flag_en,
    input logic [WIDTH-1:0]  result,
    input logic              zf,
    input logic              sf,
    input logic              of,
    input logic              bad_func
);
    localparam int MSB = WIDTH - 1;

    assert_reset_flags_R10: assert property (@(posedge clk)
        rst |=> (zf && !sf && !of));

    assert_zero_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !bad_func) |=> (zf == ($past(result) == '0)));

    assert_sign_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_en && !bad_func) |=> (sf == $past(result[MSB])));

    assert_add_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_en && func == FUNC_W'(0)) |=>
        (of == (($past(op_a[MSB]) == $past(op_b[MSB])) &&
                ($past(result[MSB]) != $past(op_a[MSB])))));

    assert_logic_clears_of_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_en && (func == FUNC_W'(2) || func == FUNC_W'(3))) |=> !of);

    assert_hold_flags_R8: assert property (@(posedge clk) disable iff (rst)
        !flag_en |=> $stable({zf, sf, of}));

    assert_invalid_hold_R9: assert property (@(posedge clk) disable iff (rst)
        bad_func |=> $stable({zf, sf, of}));

    assert_invalid_zero_R9: assert property (@(posedge clk) disable iff (rst)
        bad_func |-> (result == '0));

endmodule

bind cc_alu cc_alu_checker #(.WIDTH(WIDTH), .FUNC_W(FUNC_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .op_a     (op_a),
    .op_b     (op_b),
    .func     (func),
    .flag_en  (flag_en),
    .result   (result),
    .zf       (zf),
    .sf       (sf),
    .of       (of),
    .bad_func (bad_func)
);

// File: tb/cc_alu_tb_top.sv
`timescale 1ns/1ps
module cc_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  func = '0;
    logic        flag_en = 1'b0;
    logic [31:0] result;
    logic        zf, sf, of, bad_func;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cc_alu dut_i (
        .clk      (clk),
        .rst      (rst),
        .op_a     (op_a),
        .op_b     (op_b),
        .func     (func),
        .flag_en  (flag_en),
        .result   (result),
        .zf       (zf),
        .sf       (sf),
        .of       (of),
        .bad_func (bad_func)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_flags(input string tag, input logic ez, input logic es, input logic eo);
        check({tag, " zf"}, {31'd0, zf}, {31'd0, ez});
        check({tag, " sf"}, {31'd0, sf}, {31'd0, es});
        check({tag, " of"}, {31'd0, of}, {31'd0, eo});
    endtask

    // Drive one operation, check result same cycle, flags after the next edge.
    task automatic run_op(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [3:0] f, input logic en, input logic [31:0] eres,
                          input logic ebad, input logic ez, input logic es, input logic eo);
        @(negedge clk);
        op_a = a; op_b = b; func = f; flag_en = en;
        #1;
        check({tag, " result"}, result, eres);
        check({tag, " bad_func"}, {31'd0, bad_func}, {31'd0, ebad});
        @(negedge clk);
        check_flags(tag, ez, es, eo);
        flag_en = 1'b0;
    endtask

    task automatic test_reset_state();
        @(negedge clk);
        check_flags("R10 reset", 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_add();
        run_op("R1 add small", 32'd5, 32'd7, 4'd0, 1'b1, 32'd12, 1'b0, 1'b0, 1'b0, 1'b0);
        run_op("R5 add pos ovf", 32'd1, 32'h7fff_ffff, 4'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op("R4 add wrap zero", 32'd1, 32'hffff_ffff, 4'd0, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_op("R5 add neg ovf", 32'h8000_0000, 32'h8000_0000, 4'd0, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic test_sub();
        run_op("R2 sub neg", 32'd5, 32'd3, 4'd1, 1'b1, 32'hffff_fffe, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op("R6 sub ovf", 32'd1, 32'h8000_0000, 4'd1, 1'b1, 32'h7fff_ffff, 1'b0, 1'b0, 1'b0, 1'b1);
        run_op("R6 sub ovf pos", 32'hffff_ffff, 32'h7fff_ffff, 4'd1, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op("R4 sub equal", 32'h1234_5678, 32'h1234_5678, 4'd1, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic test_logic();
        run_op("R5 add ovf setup", 32'd1, 32'h7fff_ffff, 4'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op("R3 R7 and", 32'hf0f0_ff00, 32'h8ff0_0f0f, 4'd2, 1'b1, 32'h80f0_0f00, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op("R3 xor zero", 32'hdead_beef, 32'hdead_beef, 4'd3, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_op("R5 add ovf setup2", 32'd1, 32'h7fff_ffff, 4'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
        run_op("R3 R7 xor", 32'h0000_ffff, 32'h00ff_00ff, 4'd3, 1'b1, 32'h00ff_ff00, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_hold();
        run_op("R2 setup neg", 32'd5, 32'd3, 4'd1, 1'b1, 32'hffff_fffe, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op("R8 add disabled", 32'd1, 32'd1, 4'd0, 1'b0, 32'd2, 1'b0, 1'b0, 1'b1, 1'b0);
        run_op("R8 xor disabled", 32'd7, 32'd7, 4'd3, 1'b0, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_invalid();
        run_op("R9 func 9", 32'd5, 32'd7, 4'd9, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op("R9 func 4", 32'hffff_ffff, 32'h1, 4'd4, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        run_op("R9 func 15", 32'h8000_0000, 32'h8000_0000, 4'd15, 1'b1, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic test_reset_priority();
        run_op("R5 setup before reset", 32'd1, 32'h7fff_ffff, 4'd0, 1'b1, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1; flag_en = 1'b1; func = 4'd0; op_a = 32'd1; op_b = 32'h7fff_ffff;
        @(negedge clk);
        check_flags("R10 reset over enable", 1'b1, 1'b0, 1'b0);
        rst = 1'b0; flag_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        test_reset_state();
        rst = 1'b0;
        test_add();
        test_sub();
        test_logic();
        test_hold();
        test_invalid();
        test_reset_priority();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual not done, expected done");
            finish_run();
        end
    end

endmodule